// File: doc/BRIEF.md
# Decimal-to-BCD priority encoder

This block takes nine request lines, one each for the decimal digits 1 to 9. It returns the BCD code of the highest-numbered line that is asserted. Both the request lines and the code are active-low. Digit zero has no line of its own. It is the result when no line is asserted, and the code pins then read all ones, which is BCD 0000 after inversion. A separate active-high flag reports that no line is asserted.

A parameter selects one of two output forms. In the first, the code and flag follow the requests through combinational logic only. In the second, they are captured on the rising clock edge, with a synchronous reset that forces the idle result. Inside, the requests are first turned to active-high. A mask then keeps only the highest asserted line. The surviving one-hot line is folded into a binary code: bit 3 is set by digits 8 and 9, bit 2 by digits 4 to 7, bit 1 by digits 2, 3, 6 and 7, and bit 0 by the odd digits.

Top module: `digit_prio_enc`

## Requirements
- R1: When several lines are asserted, code_n equals the bitwise inverse of the 4-bit BCD value of the highest-numbered asserted digit.
- R2: When every bit of req_n is 1, code_n is 4'b1111 and none_active is 1.
- R3: Whenever at least one bit of req_n is 0, none_active is 0, and whenever none_active is 1, code_n is 4'b1111.
- R4: Bit k-1 of req_n is the request for digit k (k = 1 to 9), asserted when 0. With only that line asserted, code_n is ~k.
- R5: With digit 9 asserted (req_n[8] = 0), code_n is 4'b0110 whatever the state of the lower eight lines.
- R6: With only digit 3 asserted (req_n = 9'b111111011), code_n is 4'b1100, the inverse of BCD 0011.
- R7: With REGISTERED = 1, the outputs show the result for the req_n sampled at the previous rising edge. While rst is 1 at a rising edge, the next outputs are code_n = 4'b1111 and none_active = 1, whatever req_n holds.
- R8: With REGISTERED = 0, the outputs follow req_n with no clock edge in between, and clk and rst have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock for the registered output form |
| rst | input | 1 | Synchronous active-high reset of the registered output form |
| req_n | input | 9 | Active-low request lines; bit k-1 is digit k |
| code_n | output | 4 | Active-low BCD code of the highest asserted digit |
| none_active | output | 1 | High when no request line is asserted |

## Verification
The hardest case to reach from the ports is a low digit winning while several lines are asserted. For that, every line above the winner must be inactive at the same moment. Uniformly random nine-bit patterns almost always assert digit 8 or 9, so the low digits would rarely win. The stimulus therefore picks a random ceiling digit and forces every line above it high, then randomizes the lines at and below it. This gives each digit its share of contested wins.

Directed vectors add the empty pattern, each single line, the lone digit 3, and digit 9 with all lower lines asserted. Both output forms are driven side by side, and a reset is applied while every line is asserted.

// File: rtl/dpe_pkg.sv
package dpe_pkg;

   // Bits needed to carry the values 0 .. lines
   function automatic int code_bits(input int lines);
      return $clog2(lines + 1);
   endfunction

   localparam int MAX_LINES = 15;

endpackage

// File: rtl/enc_in_pol.sv
module enc_in_pol #(
   parameter int WIDTH = 9
) (
   input  logic [WIDTH-1:0] lines_n,
   output logic [WIDTH-1:0] lines
);

   // Active-low pins to active-high requests, one inverter per line
   for (genvar g = 0; g < WIDTH; g++) begin : g_inv
      assign lines[g] = ~lines_n[g];
   end

endmodule

// File: rtl/enc_prio_mask.sv
module enc_prio_mask #(
   parameter int WIDTH = 9
) (
   input  logic [WIDTH-1:0] req,
   output logic [WIDTH-1:0] grant,
   output logic             idle
);

   // Walk from the top line down; a line survives only if none above it is set
   always_comb begin
      logic seen;
      seen  = 1'b0;
      grant = '0;
      for (int i = WIDTH - 1; i >= 0; i--) begin
         grant[i] = req[i] & ~seen;
         seen     = seen | req[i];
      end
      idle = ~seen;
   end

   always_comb begin
      a_r1_single_grant: assert ($onehot0(grant));
      a_r2_idle_no_grant: assert (idle == (grant == '0));
   end

endmodule

// File: rtl/enc_onehot_code.sv
module enc_onehot_code #(
   parameter int WIDTH  = 9,
   parameter int CODE_W = 4
) (
   input  logic [WIDTH-1:0]  grant,
   output logic [CODE_W-1:0] code
);

   // Line i stands for digit i+1: OR its value into the code when granted
   always_comb begin
      code = '0;
      for (int i = 0; i < WIDTH; i++) begin
         if (grant[i]) code = code | CODE_W'(i + 1);
      end
   end

   always_comb begin
      a_r1_code_in_range: assert (code <= CODE_W'(WIDTH));
   end

endmodule

// File: rtl/enc_out_stage.sv
module enc_out_stage #(
   parameter int CODE_W     = 4,
   parameter bit REGISTERED = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [CODE_W-1:0] code,
   input  logic              idle,
   output logic [CODE_W-1:0] code_n,
   output logic              none_out
);

   if (REGISTERED) begin : g_reg
      always_ff @(posedge clk) begin
         if (rst) begin
            code_n   <= '1;
            none_out <= 1'b1;
         end else begin
            code_n   <= ~code;
            none_out <= idle;
         end
      end

      a_r7_reset_state: assert property (@(posedge clk)
         rst |=> (code_n == '1 && none_out));

      a_r7_one_cycle: assert property (@(posedge clk) disable iff (rst)
         !$past(rst) |-> (code_n == ~$past(code) && none_out == $past(idle)));
   end else begin : g_comb
      logic unused_clk_rst;
      assign unused_clk_rst = clk ^ rst;
      assign code_n   = ~code;
      assign none_out = idle;
   end

endmodule

// File: rtl/digit_prio_enc.sv
module digit_prio_enc
   import dpe_pkg::*;
#(
   parameter int NUM_LINES  = 9,
   parameter bit REGISTERED = 1'b1,
   localparam int CODE_W    = code_bits(NUM_LINES)
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic [NUM_LINES-1:0] req_n,
   output logic [CODE_W-1:0]    code_n,
   output logic                 none_active
);

   if (NUM_LINES < 1 || NUM_LINES > MAX_LINES) begin : g_bad_lines
      $error("digit_prio_enc: NUM_LINES out of range");
   end

   logic [NUM_LINES-1:0] req;
   logic [NUM_LINES-1:0] grant;
   logic                 idle;
   logic [CODE_W-1:0]    code;

   enc_in_pol #(.WIDTH(NUM_LINES)) u_pol (
      .lines_n (req_n),
      .lines   (req)
   );

   enc_prio_mask #(.WIDTH(NUM_LINES)) u_mask (
      .req   (req),
      .grant (grant),
      .idle  (idle)
   );

   enc_onehot_code #(.WIDTH(NUM_LINES), .CODE_W(CODE_W)) u_code (
      .grant (grant),
      .code  (code)
   );

   enc_out_stage #(.CODE_W(CODE_W), .REGISTERED(REGISTERED)) u_out (
      .clk      (clk),
      .rst      (rst),
      .code     (code),
      .idle     (idle),
      .code_n   (code_n),
      .none_out (none_active)
   );

   a_r3_flag_means_zero: assert property (@(posedge clk) disable iff (rst)
      none_active |-> (code_n == '1));

   a_r3_request_clears_flag: assert property (@(posedge clk) disable iff (rst)
      (!REGISTERED && !(&req_n)) |-> !none_active);

   a_r5_top_line_wins: assert property (@(posedge clk) disable iff (rst)
      (!REGISTERED && !req_n[NUM_LINES-1]) |-> (code_n == ~CODE_W'(NUM_LINES)));

endmodule

// File: tb/digit_prio_enc_bench.sv
module digit_prio_enc_bench;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [8:0] req_n = 9'h1FF;
   logic [3:0] code_r, code_c;
   logic       none_r, none_c;
   int         checks = 0;
   int         errors = 0;
   int         cycles = 0;

   always #4 clk = ~clk;

   digit_prio_enc #(.NUM_LINES(9), .REGISTERED(1'b1)) u_digit_prio_enc (
      .clk(clk), .rst(rst), .req_n(req_n), .code_n(code_r), .none_active(none_r));

   digit_prio_enc #(.NUM_LINES(9), .REGISTERED(1'b0)) u_digit_prio_enc_comb (
      .clk(clk), .rst(rst), .req_n(req_n), .code_n(code_c), .none_active(none_c));

   function automatic logic [3:0] exp_code_n(input logic [8:0] r);
      for (int d = 9; d >= 1; d--) begin
         if (!r[d-1]) return ~4'(d);
      end
      return 4'hF;
   endfunction

   function automatic logic exp_none(input logic [8:0] r);
      return &r;
   endfunction

   task automatic chk(input string tag, input logic [4:0] got, input logic [4:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got code/none %b expected %b (req_n %b)", tag, got, exp, req_n);
      end
   endtask

   // Drive at a falling edge; combinational form checked at once,
   // registered form checked at the next falling edge
   task automatic apply(input logic [8:0] v, input string tag);
      @(negedge clk);
      req_n = v;
      #1;
      chk({tag, " R8 comb"}, {code_c, none_c}, {exp_code_n(v), exp_none(v)});
      @(negedge clk);
      chk({tag, " R7 reg"}, {code_r, none_r}, {exp_code_n(v), exp_none(v)});
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
         end
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      // R7: reset dominates even with every line asserted
      req_n = 9'h000;
      rst   = 1'b1;
      repeat (3) @(negedge clk);
      chk("R7 reset state", {code_r, none_r}, {4'hF, 1'b1});
      @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      chk("R5 after reset", {code_r, none_r}, {4'b0110, 1'b0});

      apply(9'h1FF, "R2 idle");
      apply(9'b111111011, "R6 digit3 alone");
      chk("R6 value", {code_c, none_c}, {4'b1100, 1'b0});
      apply(9'b000000000, "R5 all lines");
      apply(9'b011111111, "R5 nine only");
      apply(9'b001010101, "R5 nine mixed");
      for (int k = 1; k <= 9; k++) begin
         apply(~(9'd1 << (k - 1)), "R4 single line");
      end
      apply(9'b111000000, "R1 six of low six");
      apply(9'b110101010, "R1 seven mixed");
      apply(9'b111111100, "R1 two and one");
      apply(9'h1FF, "R3 back to idle");

      // R8: comb form must not wait for clock, and rst has no effect on it
      @(negedge clk);
      rst   = 1'b1;
      req_n = 9'b111101111;
      #1;
      chk("R8 comb ignores rst", {code_c, none_c}, {4'b1010, 1'b0});
      @(negedge clk);
      chk("R7 reg in reset", {code_r, none_r}, {4'hF, 1'b1});
      rst = 1'b0;

      for (int n = 0; n < 300; n++) begin
         logic [8:0] v;
         int         ceil;
         v = 9'($urandom);
         ceil = int'($urandom_range(0, 9));
         for (int b = ceil; b < 9; b++) v[b] = 1'b1;
         apply(v, (ceil == 0) ? "R2 random idle" : "R1 random ceiling");
         if (!(&v)) chk("R3 flag low", {4'h0, none_c}, {4'h0, 1'b0});
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule